// File: doc/BRIEF.md
# Dual Word FIFO with Self-Clearing Flush

This block sits between a register port and a serial bus engine. Software pushes 32-bit words into a transmit queue and pops 32-bit words from a receive queue. A byte-wide engine port drains the transmit queue and fills the receive queue, one byte per cycle. Within each word, bytes are ordered little-endian: the first byte on the bus uses lane 0 (bits 7:0). A short final word uses only its low lanes, and its unused upper lanes are zero.

A control word holds a flush request and a trigger level for each direction. A flush request reads back as 1 while it is pending and then clears itself, so software can poll for completion. A status word reports two counts as nibbles: free transmit slots and filled receive slots. Two level outputs ask an interrupt block for service. They assert when the matching count rises above its trigger level. A write to a full transmit queue and a read from an empty receive queue each raise a one-cycle error pulse.

Top module: `word_fifo_pair`

## Requirements
- R1: After reset, control reads 0x000000E0 (transmit trigger 7, receive trigger 0, no flush pending), status reads 0x00000080, `tx_req` is 1 and `rx_req` is 0.
- R2: Control register (address 0) layout:
  - bit 0 requests a receive flush;
  - bit 1 requests a transmit flush;
  - bits 4:2 hold the receive trigger level;
  - bits 7:5 hold the transmit trigger level.

  Writing 1 to a flush bit makes it read 1 in the cycle after the write and 0 from the following cycle on.
- R3: A flush empties only its own queue, one clock after the request is accepted. A receive flush also discards a partly assembled receive word. The other queue keeps its contents.
- R4: Status register (address 1) layout: bits 7:4 give the free transmit word slots, and bits 3:0 give the filled receive words.
- R5: `tx_req` is 1 exactly while the free transmit slot count is greater than the transmit trigger level.
- R6: `rx_req` is 1 exactly while the filled receive count is greater than the receive trigger level.
- R7: A write to the transmit data address (2) while the transmit queue is full is dropped. `err_tx_overflow` is 1 in the following cycle, and the free count stays 0.
- R8: A read with `cfg_rd_en` at the receive data address (3) while the receive queue is empty returns 0. `err_rx_underflow` is 1 in the following cycle.
- R9: Receive bytes are packed little-endian, so the first byte lands in bits 7:0. A byte flagged `eng_rx_last` closes the word early, with zero in the unused upper lanes.
- R10: The transmit engine port presents the head word lane 0 first. A take with `eng_tx_last` on any lane pops the word, and the next byte is lane 0 of the next word.
- R11: Each queue holds 8 words and keeps first-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit data, 3 receive data |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rd_en | input | 1 | Read strobe; pops the receive queue at address 3 |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| err_tx_overflow | output | 1 | One-cycle pulse after a dropped transmit write |
| err_rx_underflow | output | 1 | One-cycle pulse after a read of an empty receive queue |
| eng_tx_avail | output | 1 | Transmit queue holds a word |
| eng_tx_byte | output | 8 | Current transmit byte lane |
| eng_tx_take | input | 1 | Engine consumes the current byte |
| eng_tx_last | input | 1 | Consumed byte ends the current word |
| eng_rx_ready | output | 1 | Receive side can accept a byte |
| eng_rx_valid | input | 1 | Engine delivers a byte |
| eng_rx_byte | input | 8 | Delivered byte |
| eng_rx_last | input | 1 | Delivered byte ends the current word |

## Verification
The main path is tried with three kinds of traffic:
- **Full and short words in both directions.** Lane ordering and zero fill tell a correct byte order apart from a reversed one, and a dropped short word apart from a padded one.
- **Queues stepped to counts just around the programmed triggers.** This separates a greater-than comparison from greater-or-equal, and a swapped status nibble from a correct one.
- **Flushes with the other queue loaded and a receive word half built.** These show whether a flush stays in its own direction and clears the packer, and whether the request bit reads back for exactly one cycle.

// File: rtl/wfp_pkg.sv
package wfp_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;
  localparam int LANE_W  = $clog2(LANES);
  localparam int TRIG_W  = 3;
  localparam int NIB_W   = 4;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_TXD  = 2'd2;
  localparam logic [ADDR_W-1:0] A_RXD  = 2'd3;

  localparam int B_RX_FLUSH = 0;
  localparam int B_TX_FLUSH = 1;
  localparam int B_RX_TRIG  = 2;
  localparam int B_TX_TRIG  = 5;

  localparam logic [TRIG_W-1:0] TX_TRIG_RST = 3'd7;
  localparam logic [TRIG_W-1:0] RX_TRIG_RST = 3'd0;

  function automatic logic [WORD_W-1:0] lane_put(input logic [WORD_W-1:0] w,
                                                 input logic [LANE_W-1:0] lane,
                                                 input logic [7:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    r[{lane, 3'b000} +: 8] = b;
    return r;
  endfunction

  function automatic logic [7:0] lane_get(input logic [WORD_W-1:0] w,
                                          input logic [LANE_W-1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic above_trig(input logic [NIB_W-1:0] level,
                                      input logic [TRIG_W-1:0] trig);
    return level > {{(NIB_W-TRIG_W){1'b0}}, trig};
  endfunction
endpackage

// File: rtl/wfp_word_fifo.sv
module wfp_word_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P  = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_p, rd_p;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == DEPTH_C);
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rd_p];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_p] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p  <= '0;
      rd_p  <= '0;
      count <= '0;
    end else if (flush) begin
      wr_p  <= '0;
      rd_p  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wr_p <= step(wr_p);
      if (pop_ok)  rd_p <= step(rd_p);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wfp_rx_packer.sv
module wfp_rx_packer
  import wfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  output logic              out_push,
  output logic [WORD_W-1:0] out_word
);
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

  logic [WORD_W-1:0] acc;
  logic [LANE_W-1:0] lane;

  assign out_word = lane_put(acc, lane, in_byte);
  assign out_push = in_valid && (in_last || lane == TOP_LANE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      lane <= '0;
    end else if (clear || out_push) begin
      acc  <= '0;
      lane <= '0;
    end else if (in_valid) begin
      acc  <= out_word;
      lane <= lane + 1'b1;
    end
  end
endmodule

// File: rtl/wfp_tx_unpacker.sv
module wfp_tx_unpacker
  import wfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [WORD_W-1:0] head,
  input  logic              avail,
  input  logic              take,
  input  logic              last,
  output logic [7:0]        out_byte,
  output logic              pop
);
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

  logic [LANE_W-1:0] lane;
  logic              step_ok;

  assign out_byte = lane_get(head, lane);
  assign step_ok  = take && avail;
  assign pop      = step_ok && (last || lane == TOP_LANE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lane <= '0;
    else if (clear || pop)     lane <= '0;
    else if (step_ok)          lane <= lane + 1'b1;
  end
endmodule

// File: rtl/word_fifo_pair.sv
module word_fifo_pair
  import wfp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr_en,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              cfg_rd_en,
  output logic [WORD_W-1:0] cfg_rdata,
  output logic              tx_req,
  output logic              rx_req,
  output logic              err_tx_overflow,
  output logic              err_rx_underflow,
  output logic              eng_tx_avail,
  output logic [7:0]        eng_tx_byte,
  input  logic              eng_tx_take,
  input  logic              eng_tx_last,
  output logic              eng_rx_ready,
  input  logic              eng_rx_valid,
  input  logic [7:0]        eng_rx_byte,
  input  logic              eng_rx_last
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic              tx_flush_pend, rx_flush_pend;

  logic wr_ctrl, wr_txd, rd_rxd;
  logic tx_drop, rx_starve;

  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic [CNT_W-1:0]  tx_count, rx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic              tx_pop, rx_push;
  logic [7:0]        tx_free_w, rx_cnt_w;
  logic [NIB_W-1:0]  tx_free_nib, rx_cnt_nib;

  assign wr_ctrl   = cfg_wr_en && (cfg_addr == A_CTRL);
  assign wr_txd    = cfg_wr_en && (cfg_addr == A_TXD);
  assign rd_rxd    = cfg_rd_en && (cfg_addr == A_RXD);
  assign tx_drop   = wr_txd && tx_full;
  assign rx_starve = rd_rxd && rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_trig          <= TX_TRIG_RST;
      rx_trig          <= RX_TRIG_RST;
      tx_flush_pend    <= 1'b0;
      rx_flush_pend    <= 1'b0;
      err_tx_overflow  <= 1'b0;
      err_rx_underflow <= 1'b0;
    end else begin
      err_tx_overflow  <= tx_drop;
      err_rx_underflow <= rx_starve;
      if (wr_ctrl) begin
        tx_trig       <= cfg_wdata[B_TX_TRIG +: TRIG_W];
        rx_trig       <= cfg_wdata[B_RX_TRIG +: TRIG_W];
        tx_flush_pend <= cfg_wdata[B_TX_FLUSH];
        rx_flush_pend <= cfg_wdata[B_RX_FLUSH];
      end else begin
        tx_flush_pend <= 1'b0;
        rx_flush_pend <= 1'b0;
      end
    end
  end

  wfp_word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush_pend),
    .push(wr_txd), .push_data(cfg_wdata), .pop(tx_pop),
    .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  wfp_word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush_pend),
    .push(rx_push), .push_data(rx_word), .pop(rd_rxd),
    .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  wfp_tx_unpacker u_unpack (
    .clk(clk), .rst_n(rst_n), .clear(tx_flush_pend),
    .head(tx_head), .avail(!tx_empty), .take(eng_tx_take), .last(eng_tx_last),
    .out_byte(eng_tx_byte), .pop(tx_pop)
  );

  wfp_rx_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clear(rx_flush_pend),
    .in_valid(eng_rx_valid), .in_byte(eng_rx_byte), .in_last(eng_rx_last),
    .out_push(rx_push), .out_word(rx_word)
  );

  assign eng_tx_avail = !tx_empty && !tx_flush_pend;
  assign eng_rx_ready = !rx_full && !rx_flush_pend;

  assign tx_free_w   = 8'(DEPTH_C - tx_count);
  assign rx_cnt_w    = 8'(rx_count);
  assign tx_free_nib = tx_free_w[NIB_W-1:0];
  assign rx_cnt_nib  = rx_cnt_w[NIB_W-1:0];

  assign tx_req = above_trig(tx_free_nib, tx_trig);
  assign rx_req = above_trig(rx_cnt_nib, rx_trig);

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      A_CTRL: cfg_rdata = WORD_W'({tx_trig, rx_trig, tx_flush_pend, rx_flush_pend});
      A_STAT: cfg_rdata = WORD_W'({tx_free_nib, rx_cnt_nib});
      A_RXD:  cfg_rdata = rx_empty ? '0 : rx_head;
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wfp_checker.sv
module wfp_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ctrl,
  input logic [31:0]      cfg_wdata,
  input logic             tx_flush_pend,
  input logic             rx_flush_pend,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic             tx_drop,
  input logic             rx_starve,
  input logic             err_tx_overflow,
  input logic             err_rx_underflow,
  input logic             tx_push_ok,
  input logic             tx_pop_ok
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  // R2: an accepted flush request is pending in the next cycle
  a_r2_flush_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && cfg_wdata[0]) |=> rx_flush_pend);
  // R2: a pending flush clears itself unless requested again
  a_r2_tx_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush_pend && !wr_ctrl) |=> !tx_flush_pend);
  // R3: a receive flush leaves the receive queue empty
  a_r3_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_pend |=> (rx_count == '0));
  // R3: a transmit flush leaves the transmit queue empty
  a_r3_tx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_pend |=> (tx_count == '0));
  // R7: dropped transmit write raises the overflow pulse
  a_r7_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> err_tx_overflow);
  // R8: read of an empty receive queue raises the underflow pulse
  a_r8_underflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_starve |=> err_rx_underflow);
  // R11: occupancy never exceeds the depth
  a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= DEPTH_C) && (rx_count <= DEPTH_C));
  // R11: a lone accepted push grows the transmit count by one
  a_r11_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_ok && !tx_pop_ok && !tx_flush_pend) |=> (tx_count == $past(tx_count) + 1'b1));
endmodule

bind word_fifo_pair wfp_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_wfp_checker (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .cfg_wdata(cfg_wdata),
  .tx_flush_pend(tx_flush_pend), .rx_flush_pend(rx_flush_pend),
  .tx_count(tx_count), .rx_count(rx_count),
  .tx_drop(tx_drop), .rx_starve(rx_starve),
  .err_tx_overflow(err_tx_overflow), .err_rx_underflow(err_rx_underflow),
  .tx_push_ok(tx_push_ok), .tx_pop_ok(tx_pop_ok)
);

// File: tb/test_word_fifo_pair.sv
module test_word_fifo_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rd_en = 1'b0;
  logic [31:0] cfg_rdata;
  logic        tx_req, rx_req, err_tx_overflow, err_rx_underflow;
  logic        eng_tx_avail, eng_tx_take = 1'b0, eng_tx_last = 1'b0;
  logic [7:0]  eng_tx_byte;
  logic        eng_rx_ready, eng_rx_valid = 1'b0, eng_rx_last = 1'b0;
  logic [7:0]  eng_rx_byte = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] rd_exp_q[$];
  logic [7:0]  tx_exp_q[$];
  bit          tx_last_q[$];

  always #5 clk = ~clk;

  word_fifo_pair i_word_fifo_pair (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
    .cfg_wdata(cfg_wdata), .cfg_rd_en(cfg_rd_en), .cfg_rdata(cfg_rdata),
    .tx_req(tx_req), .rx_req(rx_req), .err_tx_overflow(err_tx_overflow),
    .err_rx_underflow(err_rx_underflow), .eng_tx_avail(eng_tx_avail),
    .eng_tx_byte(eng_tx_byte), .eng_tx_take(eng_tx_take), .eng_tx_last(eng_tx_last),
    .eng_rx_ready(eng_rx_ready), .eng_rx_valid(eng_rx_valid),
    .eng_rx_byte(eng_rx_byte), .eng_rx_last(eng_rx_last)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input bit pop, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_rd_en = pop;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_rd_en = 1'b0;
  endtask

  // driver: transmit word with nbytes valid, expected bytes queued lane 0 first
  task automatic tx_word(input logic [31:0] w, input int nbytes);
    reg_wr(2'd2, w);
    for (int i = 0; i < nbytes; i++) begin
      tx_exp_q.push_back(8'((w >> (8 * i)) & 32'hFF));
      tx_last_q.push_back((i == nbytes - 1) && (nbytes < 4));
    end
  endtask

  // monitor: engine consumes bytes and compares against the scoreboard
  task automatic tx_drain();
    while (tx_exp_q.size() > 0) begin
      logic [7:0] e;
      bit l;
      e = tx_exp_q.pop_front();
      l = tx_last_q.pop_front();
      @(negedge clk);
      check(eng_tx_avail == 1'b1, "R10 avail", 32'(eng_tx_avail), 32'd1);
      check(eng_tx_byte == e, "R10 R11 byte order", 32'(eng_tx_byte), 32'(e));
      eng_tx_take = 1'b1; eng_tx_last = l;
      @(negedge clk);
      eng_tx_take = 1'b0; eng_tx_last = 1'b0;
    end
  endtask

  // driver: engine delivers bytes, expected words assembled little-endian
  task automatic rx_send(input logic [7:0] b[$], input bit end_short);
    logic [31:0] w = '0;
    for (int i = 0; i < b.size(); i++) begin
      bit l;
      w = w | (32'(b[i]) << (8 * (i % 4)));
      l = end_short && (i == b.size() - 1);
      @(negedge clk);
      eng_rx_valid = 1'b1; eng_rx_byte = b[i]; eng_rx_last = l;
      @(negedge clk);
      eng_rx_valid = 1'b0; eng_rx_last = 1'b0;
      if ((i % 4) == 3 || l) begin
        rd_exp_q.push_back(w);
        w = '0;
      end
    end
  endtask

  task automatic rx_collect(input string req);
    while (rd_exp_q.size() > 0) begin
      logic [31:0] d, e;
      e = rd_exp_q.pop_front();
      reg_rd(2'd3, 1'b1, d);
      check(d == e, req, d, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] bq[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(2'd0, 1'b0, d); check(d == 32'hE0, "R1 ctrl", d, 32'hE0);
    reg_rd(2'd1, 1'b0, d); check(d == 32'h80, "R1 status", d, 32'h80);
    check(tx_req == 1'b1, "R1 tx_req", 32'(tx_req), 32'd1);
    check(rx_req == 1'b0, "R1 rx_req", 32'(rx_req), 32'd0);

    // R10 full word then short word
    tx_word(32'h44332211, 4);
    tx_word(32'h00CCBBAA, 3);
    reg_rd(2'd1, 1'b0, d); check(d == 32'h60, "R4 two tx words", d, 32'h60);
    tx_drain();
    reg_rd(2'd1, 1'b0, d); check(d == 32'h80, "R4 tx drained", d, 32'h80);
    check(eng_tx_avail == 1'b0, "R10 empty", 32'(eng_tx_avail), 32'd0);

    // R9 receive packing
    bq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    rx_send(bq, 1'b1);
    reg_rd(2'd1, 1'b0, d); check(d == 32'h82, "R4 rx count", d, 32'h82);
    check(rx_req == 1'b1, "R6 rx_req trig0", 32'(rx_req), 32'd1);
    rx_collect("R9 R11 rx word");
    reg_rd(2'd3, 1'b1, d); check(d == 32'h0, "R8 empty read", d, 32'h0);
    check(err_rx_underflow == 1'b1, "R8 underflow", 32'(err_rx_underflow), 32'd1);

    // R2 R5 R6 trigger levels
    reg_wr(2'd0, 32'h64);
    reg_rd(2'd0, 1'b0, d); check(d == 32'h64, "R2 ctrl readback", d, 32'h64);
    for (int i = 0; i < 4; i++) reg_wr(2'd2, 32'h1000 + 32'(i));
    check(tx_req == 1'b1, "R5 free4 trig3", 32'(tx_req), 32'd1);
    reg_wr(2'd2, 32'h2000);
    check(tx_req == 1'b0, "R5 free3 trig3", 32'(tx_req), 32'd0);
    bq = '{8'h10, 8'h11, 8'h12, 8'h13};
    rx_send(bq, 1'b0);
    check(rx_req == 1'b0, "R6 cnt1 trig1", 32'(rx_req), 32'd0);
    bq = '{8'h20, 8'h21, 8'h22, 8'h23};
    rx_send(bq, 1'b0);
    check(rx_req == 1'b1, "R6 cnt2 trig1", 32'(rx_req), 32'd1);

    // R7 overflow
    for (int i = 0; i < 3; i++) reg_wr(2'd2, 32'h3000 + 32'(i));
    reg_rd(2'd1, 1'b0, d); check(d == 32'h02, "R4 tx full", d, 32'h02);
    check(err_tx_overflow == 1'b0, "R7 no pulse yet", 32'(err_tx_overflow), 32'd0);
    reg_wr(2'd2, 32'hDEAD);
    check(err_tx_overflow == 1'b1, "R7 overflow", 32'(err_tx_overflow), 32'd1);
    reg_rd(2'd1, 1'b0, d); check(d == 32'h02, "R7 still full", d, 32'h02);

    // R2 R3 transmit flush only
    reg_wr(2'd0, 32'h66);
    cfg_addr = 2'd0; #1 d = cfg_rdata;
    check(d == 32'h66, "R2 flush pending", d, 32'h66);
    reg_rd(2'd0, 1'b0, d); check(d == 32'h64, "R2 flush cleared", d, 32'h64);
    reg_rd(2'd1, 1'b0, d); check(d == 32'h82, "R3 tx flushed rx kept", d, 32'h82);

    // R3 receive flush drops words and the partial word
    bq = '{8'h77};
    rx_send(bq, 1'b0);
    reg_wr(2'd0, 32'h65);
    rd_exp_q.delete();
    reg_rd(2'd1, 1'b0, d); check(d == 32'h80, "R3 rx flushed", d, 32'h80);
    bq = '{8'h11, 8'h22};
    rx_send(bq, 1'b1);
    rx_collect("R3 R9 packer cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule